// File: doc/BRIEF.md
# CSMA/CD Transmit Access Controller

This block decides when a half-duplex transmitter may put a frame on a shared medium, and it reports how each frame attempt ended. One clock cycle is one bit time. A request waits until the medium has been quiet for the inter-packet gap, and it holds off while carrier is present. A collision inside the slot time starts a jam and then a truncated binary exponential backoff drawn from an LFSR. After a set number of collisions the frame is abandoned. A collision past the slot time ends the frame without a retry. After a normal end, the block waits for the transceiver's SQE heartbeat. If the transmit FIFO runs dry mid-frame, the block tells the serialiser to spoil the frame so that receivers drop it.

The state machine has seven states. IDLE goes to DEFER on a frame request. DEFER goes to XMIT once carrier is absent and the gap has elapsed. From XMIT the block goes to JAM on a collision. It goes to SQE at the last bit, or on underflow when runt mode is chosen. JAM lasts the jam length. It then goes to BACKOFF, or to REPORT if the frame is abandoned. BACKOFF counts down its slots and returns to DEFER. SQE goes to REPORT on a heartbeat or when its window runs out. REPORT lasts one cycle and returns to IDLE.

Top module: `csma_tx_ctrl`

## Requirements
- R1: `tx_en` rises only after `carrier_sense` has been low for at least IPG_BITS (96) consecutive cycles.
- R2: If `carrier_sense` is high while a request waits before its first transmission, status bit 0 (deferred) is set.
- R3: A collision while transmitting, before SLOT_BITS bit times, causes a jam of exactly JAM_BITS (32) cycles with `jam_req` and `tx_en` high. It is followed by a backoff of r slots, with 0 <= r < 2^min(n,10) after collision n, and then a new contention that again honours R1.
- R4: Status bit 1 is set when the frame needed exactly one retry. Status bit 2 is set when it needed more than one. At most one of bits 1, 2 and 3 is ever set.
- R5: On the MAX_ATTEMPTS-th (16th) early collision, the frame is abandoned after the jam. Status bit 3 is set and bits 1 and 2 are clear.
- R6: Status bit 4 is set if `carrier_sense` is low during the block's own transmission, from CRS_LEAD bit times after its start.
- R7: A collision at or after SLOT_BITS bit times sets status bit 5. The frame then ends after the jam with no retry.
- R8: After a normal end, an `sqe_in` pulse within SQE_WINDOW (64) cycles leaves status bit 6 clear. Without such a pulse, bit 6 is set.
- R9: When `fifo_empty` is high during transmission, `tx_spoil` goes high. In bad-FCS mode (the default) it stays high to the last bit and the frame continues. In runt mode the frame ends at once. `tx_spoil` is never high for a frame without underflow.
- R10: `status_valid` is a single-cycle pulse with the status word, once per frame. After reset the outputs are all low.
- R11: `jam_req` is high only while `tx_en` is high. A collision while the block is not transmitting has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_sense | input | 1 | Medium busy |
| collision | input | 1 | Collision detected |
| frame_req | input | 1 | Frame waiting to be sent (held until status_valid) |
| fifo_empty | input | 1 | Transmit FIFO has no data for the next bit |
| tx_last | input | 1 | Serialiser is sending the last bit |
| sqe_in | input | 1 | SQE heartbeat from the transceiver |
| tx_en | output | 1 | Drive the medium (frame or jam) |
| jam_req | output | 1 | Send jam pattern |
| tx_spoil | output | 1 | Corrupt FCS / truncate the frame |
| status_valid | output | 1 | Status word valid, one cycle |
| status | output | 7 | {cerr, lcol, lcar, rtry, more, one, def}, bit 0 = def |

## Verification
The bench targets the cases that are easiest to get wrong. Carrier that ends just before a request must still leave a full gap; a design that counts the gap from the request would start early. A collision after the slot time must not be retried; a design that treats it as early would report a retry instead of a late collision. The sixteenth collision must abandon the frame with only the exhausted flag set; an off-by-one would retry once more or report MORE. A missing heartbeat must set the SQE error flag, and an underflow must keep the spoil command high through the last bit.

// File: rtl/csma_pkg.sv
package csma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEFER,
        ST_XMIT,
        ST_JAM,
        ST_BACKOFF,
        ST_SQE,
        ST_REPORT
    } tx_state_e;

    // Packed MSB first: def is bit 0, cerr is bit 6.
    typedef struct packed {
        logic cerr;
        logic lcol;
        logic lcar;
        logic rtry;
        logic more;
        logic one;
        logic def;
    } tx_status_t;

endpackage

// File: rtl/csma_backoff_lfsr.sv
module csma_backoff_lfsr #(
    parameter int          WIDTH = 16,
    parameter logic [15:0] TAPS  = 16'hB400,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] value
);
    logic [WIDTH-1:0] state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WIDTH'(SEED);
        end else if (state_q[0]) begin
            state_q <= (state_q >> 1) ^ WIDTH'(TAPS);
        end else begin
            state_q <= state_q >> 1;
        end
    end

    assign value = state_q;

    // A zero state would freeze the backoff draw.
    p_lfsr_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

endmodule

// File: rtl/csma_gap_tracker.sv
module csma_gap_tracker #(
    parameter int IPG_BITS = 96
) (
    input  logic clk,
    input  logic rst_n,
    input  logic carrier,
    output logic gap_ok
);
    localparam int GW = $clog2(IPG_BITS + 1);
    localparam logic [GW-1:0] GAP_FULL = GW'(IPG_BITS);

    logic [GW-1:0] quiet_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q <= GAP_FULL;
        end else if (carrier) begin
            quiet_q <= '0;
        end else if (quiet_q != GAP_FULL) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    assign gap_ok = (quiet_q == GAP_FULL);

    p_busy_restarts_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        carrier |=> !gap_ok);

endmodule

// File: rtl/csma_tx_ctrl.sv
module csma_tx_ctrl
    import csma_pkg::*;
#(
    parameter int          IPG_BITS       = 96,
    parameter int          SLOT_BITS      = 512,
    parameter int          JAM_BITS       = 32,
    parameter int          MAX_ATTEMPTS   = 16,
    parameter int          BACKOFF_CAP    = 10,
    parameter int          SQE_WINDOW     = 64,
    parameter int          CRS_LEAD       = 2,
    parameter bit          UNDERFLOW_RUNT = 1'b0,
    parameter int          LFSR_W         = 16,
    parameter logic [15:0] LFSR_SEED      = 16'hACE1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       carrier_sense,
    input  logic       collision,
    input  logic       frame_req,
    input  logic       fifo_empty,
    input  logic       tx_last,
    input  logic       sqe_in,
    output logic       tx_en,
    output logic       jam_req,
    output logic       tx_spoil,
    output logic       status_valid,
    output logic [6:0] status
);
    localparam int CNT_W = $clog2(SLOT_BITS + IPG_BITS + JAM_BITS + SQE_WINDOW + 1);
    localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1);
    localparam int BO_W  = BACKOFF_CAP;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] SLOT_C  = CNT_W'(SLOT_BITS);
    localparam logic [CNT_W-1:0] JAM_C   = CNT_W'(JAM_BITS);
    localparam logic [CNT_W-1:0] SQE_C   = CNT_W'(SQE_WINDOW);
    localparam logic [CNT_W-1:0] LEAD_C  = CNT_W'(CRS_LEAD);
    localparam logic [ATT_W-1:0] ATT_MAX = ATT_W'(MAX_ATTEMPTS);
    localparam logic [ATT_W-1:0] CAP_A   = ATT_W'(BACKOFF_CAP);

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [ATT_W-1:0] attempts_q;
    logic [BO_W-1:0]  bo_q;
    logic [BO_W-1:0]  bo_mask;
    logic [ATT_W-1:0] bo_exp;
    logic [LFSR_W-1:0] lfsr_val;
    logic             gap_ok;
    logic             started_q, uf_q;
    logic             def_q, lcar_q, lcol_q, cerr_q;
    tx_status_t       word;

    csma_gap_tracker #(.IPG_BITS(IPG_BITS)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .carrier (carrier_sense),
        .gap_ok  (gap_ok)
    );

    csma_backoff_lfsr #(.WIDTH(LFSR_W), .SEED(LFSR_SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (lfsr_val)
    );

    // Truncated exponent: window grows with each collision up to the cap.
    assign bo_exp  = (attempts_q > CAP_A) ? CAP_A : attempts_q;
    assign bo_mask = ~({BO_W{1'b1}} << bo_exp);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (frame_req) state_d = ST_DEFER;
            ST_DEFER:   if (!carrier_sense && gap_ok) state_d = ST_XMIT;
            ST_XMIT: begin
                if (collision)                          state_d = ST_JAM;
                else if (UNDERFLOW_RUNT && fifo_empty)  state_d = ST_SQE;
                else if (tx_last)                       state_d = ST_SQE;
            end
            ST_JAM: begin
                if (cnt_q == JAM_C - 1'b1)
                    state_d = (lcol_q || attempts_q == ATT_MAX) ? ST_REPORT : ST_BACKOFF;
            end
            ST_BACKOFF: if (bo_q == '0) state_d = ST_DEFER;
            ST_SQE: begin
                if (sqe_in || cnt_q == SQE_C - 1'b1) state_d = ST_REPORT;
            end
            ST_REPORT:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and shared bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                cnt_q <= '0;
            else if (state_q == ST_BACKOFF && cnt_q == SLOT_C - 1'b1)
                cnt_q <= '0;
            else if (cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // Per-frame outcome tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            attempts_q <= '0;
            bo_q       <= '0;
            started_q  <= 1'b0;
            uf_q       <= 1'b0;
            def_q      <= 1'b0;
            lcar_q     <= 1'b0;
            lcol_q     <= 1'b0;
            cerr_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (frame_req) begin
                        attempts_q <= '0;
                        started_q  <= 1'b0;
                        uf_q       <= 1'b0;
                        def_q      <= 1'b0;
                        lcar_q     <= 1'b0;
                        lcol_q     <= 1'b0;
                        cerr_q     <= 1'b0;
                    end
                end
                ST_DEFER: begin
                    if (carrier_sense && !started_q) def_q <= 1'b1;
                end
                ST_XMIT: begin
                    started_q <= 1'b1;
                    if (cnt_q >= LEAD_C && !carrier_sense) lcar_q <= 1'b1;
                    if (collision) begin
                        if (cnt_q >= SLOT_C) lcol_q <= 1'b1;
                        else                 attempts_q <= attempts_q + 1'b1;
                    end else if (fifo_empty) begin
                        uf_q <= 1'b1;
                    end
                end
                ST_JAM: begin
                    if (state_d == ST_BACKOFF) bo_q <= lfsr_val[BO_W-1:0] & bo_mask;
                end
                ST_BACKOFF: begin
                    if (cnt_q == SLOT_C - 1'b1 && bo_q != '0) bo_q <= bo_q - 1'b1;
                end
                ST_SQE: begin
                    if (state_d == ST_REPORT && !sqe_in) cerr_q <= 1'b1;
                end
                ST_REPORT: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        word.def  = def_q;
        word.rtry = (attempts_q == ATT_MAX);
        word.one  = (attempts_q == ATT_W'(1)) && !word.rtry;
        word.more = (attempts_q >  ATT_W'(1)) && !word.rtry;
        word.lcar = lcar_q;
        word.lcol = lcol_q;
        word.cerr = cerr_q;

        tx_en        = (state_q == ST_XMIT) || (state_q == ST_JAM);
        jam_req      = (state_q == ST_JAM);
        tx_spoil     = (state_q == ST_XMIT) && (uf_q || (fifo_empty && !collision));
        status_valid = (state_q == ST_REPORT);
        status       = status_valid ? word : '0;
    end

    p_gap_before_tx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> gap_ok);

    p_backoff_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BACKOFF) |-> ((bo_q & ~bo_mask) == '0));

    p_outcome_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid |-> $onehot0(status[3:1]));

    p_attempt_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        attempts_q <= ATT_MAX);

    p_late_no_retry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JAM && lcol_q) |=> (state_q == ST_JAM || state_q == ST_REPORT));

    p_status_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid |=> !status_valid);

    p_jam_on_medium_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jam_req) |-> $past(tx_en));

endmodule

// File: tb/csma_tx_ctrl_test.sv
`timescale 1ns/1ps
module csma_tx_ctrl_test;
    localparam int IPG    = 96;
    localparam int SLOT   = 8;
    localparam int JAM    = 32;
    localparam int LEN    = 30;
    localparam int UF_AT  = 10;
    localparam int SQE_AT = 10;

    typedef struct packed {
        logic       pre;
        logic [4:0] ncoll;
        logic       late;
        logic       loop;
        logic       uf;
        logic       sqe;
        logic [6:0] exp;
    } vec_t;

    // status bits: 0 def, 1 one, 2 more, 3 rtry, 4 lcar, 5 lcol, 6 cerr
    localparam vec_t VECS [12] = '{
        '{1'b0, 5'd0,  1'b0, 1'b1, 1'b0, 1'b1, 7'b0000000},
        '{1'b1, 5'd0,  1'b0, 1'b1, 1'b0, 1'b1, 7'b0000001},
        '{1'b0, 5'd1,  1'b0, 1'b1, 1'b0, 1'b1, 7'b0000010},
        '{1'b0, 5'd2,  1'b0, 1'b1, 1'b0, 1'b1, 7'b0000100},
        '{1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 1'b1, 7'b0010000},
        '{1'b0, 5'd1,  1'b1, 1'b1, 1'b0, 1'b1, 7'b0100000},
        '{1'b0, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 7'b1000000},
        '{1'b0, 5'd0,  1'b0, 1'b1, 1'b1, 1'b1, 7'b0000000},
        '{1'b0, 5'd16, 1'b0, 1'b1, 1'b0, 1'b1, 7'b0001000},
        '{1'b0, 5'd1,  1'b0, 1'b1, 1'b0, 1'b0, 7'b1000010},
        '{1'b1, 5'd1,  1'b0, 1'b1, 1'b0, 1'b1, 7'b0000011},
        '{1'b0, 5'd3,  1'b0, 1'b1, 1'b1, 1'b0, 7'b1000100}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_crs = 1'b0, loop_en = 1'b1;
    logic collision = 1'b0, frame_req = 1'b0, fifo_empty = 1'b0;
    logic tx_last = 1'b0, sqe_in = 1'b0;
    logic carrier_sense;
    logic tx_en, jam_req, tx_spoil, status_valid;
    logic [6:0] status;
    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    assign carrier_sense = ext_crs | (tx_en & loop_en);

    csma_tx_ctrl #(
        .IPG_BITS(IPG), .SLOT_BITS(SLOT), .JAM_BITS(JAM), .SQE_WINDOW(64)
    ) uut (
        .clk(clk), .rst_n(rst_n), .carrier_sense(carrier_sense),
        .collision(collision), .frame_req(frame_req), .fifo_empty(fifo_empty),
        .tx_last(tx_last), .sqe_in(sqe_in), .tx_en(tx_en), .jam_req(jam_req),
        .tx_spoil(tx_spoil), .status_valid(status_valid), .status(status)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int txbits = 0, attempt = 0, jam_run = 0, last_jam = 0;
        int since_jam = 0, since_crs = 1000, since_tx = 1000;
        int min_gap = 1 << 30, max_gap = 0, crs_to_tx = -1;
        int cbit;
        logic x, prev_x = 1'b0, done = 1'b0, spoil_end = 1'b0;
        logic [6:0] got = '0;
        cbit = v.late ? 20 : 3;
        loop_en = v.loop;
        for (int cyc = 0; cyc < 100000 && !done; cyc++) begin
            @(negedge clk);
            if (status_valid) begin got = status; done = 1'b1; end
            x = tx_en && !jam_req;
            if (jam_req) begin
                jam_run++;
                since_jam = 0;
            end else begin
                if (jam_run != 0) last_jam = jam_run;
                jam_run = 0;
                since_jam++;
            end
            if (ext_crs) since_crs = 0; else since_crs++;
            if (tx_en) since_tx = 0; else since_tx++;
            if (x && !prev_x) begin
                attempt++;
                if (attempt == 1) crs_to_tx = since_crs;
                else begin
                    if (since_jam < min_gap) min_gap = since_jam;
                    if (since_jam > max_gap) max_gap = since_jam;
                end
            end
            if (x) txbits++; else txbits = 0;
            if (x && txbits == LEN && tx_spoil) spoil_end = 1'b1;
            prev_x = x;
            frame_req  = !done;
            ext_crs    = v.pre && cyc < 20;
            collision  = x && txbits == cbit && attempt <= int'(v.ncoll);
            fifo_empty = v.uf && x && txbits == UF_AT;
            tx_last    = x && txbits == LEN;
            sqe_in     = v.sqe && since_tx == SQE_AT;
        end
        frame_req = 1'b0; collision = 1'b0; fifo_empty = 1'b0;
        tx_last = 1'b0; sqe_in = 1'b0; ext_crs = 1'b0;
        if (!done) begin
            check($sformatf("vec%0d R10 status_valid never seen", idx), 0, 1);
        end else begin
            check($sformatf("vec%0d status R2 R4 R5 R6 R7 R8", idx), int'(got), int'(v.exp));
        end
        check($sformatf("vec%0d R9 tx_spoil at last bit", idx), int'(spoil_end), int'(v.uf));
        if (v.ncoll != 0 && done)
            check($sformatf("vec%0d R3 jam length", idx), last_jam, JAM);
        if (v.ncoll != 0 && v.ncoll <= 3 && !v.late) begin
            check($sformatf("vec%0d R3 retry gap lower bound", idx), int'(min_gap >= IPG), 1);
            check($sformatf("vec%0d R3 retry gap upper bound", idx),
                  int'(max_gap <= IPG + ((1 << int'(v.ncoll)) - 1) * SLOT + 4), 1);
        end
        if (v.pre)
            check($sformatf("vec%0d R1 carrier-to-tx gap", idx),
                  int'(crs_to_tx >= IPG && crs_to_tx <= IPG + 4), 1);
        repeat (10) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        check("R10 reset tx_en", int'(tx_en), 0);
        check("R10 reset jam_req", int'(jam_req), 0);
        check("R10 reset tx_spoil", int'(tx_spoil), 0);
        check("R10 reset status_valid", int'(status_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        foreach (VECS[i]) run_vec(VECS[i], i);

        // R11: collision with no frame pending is ignored
        begin
            logic any_out = 1'b0;
            for (int k = 0; k < 40; k++) begin
                collision = (k % 3 == 0);
                @(negedge clk);
                if (tx_en || jam_req || status_valid || tx_spoil) any_out = 1'b1;
            end
            collision = 1'b0;
            check("R11 idle collision ignored", int'(any_out), 0);
        end

        // R1: medium idle for long -> tx_en two cycles after request
        begin
            int wait_c = 0;
            frame_req = 1'b1;
            while (!tx_en && wait_c < 20) begin
                @(negedge clk);
                wait_c++;
            end
            check("R1 start latency on quiet medium", wait_c, 2);
            tx_last = 1'b1;
            @(negedge clk);
            tx_last = 1'b0;
            wait_c = 0;
            while (!status_valid && wait_c < 200) begin
                @(negedge clk);
                wait_c++;
            end
            frame_req = 1'b0;
            check("R8 status cerr without heartbeat", int'(status), 7'b1000000);
        end

        finish_run();
    end
endmodule